// File: doc/BRIEF.md
# Multichannel PCM Stream Packer

This block takes one frame of parallel PCM samples, one per active audio channel, together with a validity, user and channel-status bit for each channel. It sends them out as a sequence of 32-bit words on an AXI4-Stream master, one word per channel. Each word carries the sample placed in a 24-bit field, the three side bits, an even-parity bit computed over everything above the low nibble, and a 4-bit preamble code in the low nibble. The 3-bit stream ID carries the channel number.

A producer offers a frame with `in_valid`. The block takes the frame in one cycle when `in_ready` is high. It then emits the channels in ascending order and honours backpressure on `m_tready`. It raises `in_ready` again only after the last channel word of the frame has been transferred. A frame counter groups frames into audio blocks. The first channel word of the first frame of each block is marked with a distinct preamble code, so a downstream serializer can find block boundaries. The channel count must be even, from 2 to 8. The sample width is 16 or 24. Both are parameters.

Top module: `pcm_stream_packer`

## Requirements
- R1: Every output word is laid out as parity in bit 31, channel-status in bit 30, user in bit 29, validity in bit 28, the sample field in bits 27:4 and the preamble code in bits 3:0. The three side bits are copied from the channel's input bits.
- R2: The word for channel 0 of the first frame after reset, and of every frame whose index is a multiple of `FRAMES_PER_BLOCK` frames, carries preamble code 4'b0001.
- R3: Every other word carries preamble 4'b0010 when its channel ID is even and 4'b0011 when it is odd.
- R4: Within a frame, words leave with `m_tid` equal to 0, 1, … up to `NUM_CH-1`, in that order. The next frame starts again at 0.
- R5: With `SAMPLE_W` = 24, bits 27:4 equal the channel's 24-bit sample.
- R6: With `SAMPLE_W` = 16, bits 27:12 equal the sample and bits 11:4 are zero.
- R7: Bits 31:4 of every word together hold an even number of ones.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tid` hold their values into the next cycle.
- R9: `in_ready` is high exactly when no word is pending on the output. Input data presented while `in_ready` is low has no effect on any output word.
- R10: Channel 0 of each frame that is not the first frame of a block carries preamble 4'b0010. The block count restarts every `FRAMES_PER_BLOCK` frames.
- R11: A synchronous active-high reset clears `m_tvalid`, raises `in_ready`, and makes the next frame frame 0 starting at channel 0. This holds even when the reset comes in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A frame of samples is offered |
| in_ready | output | 1 | The block can take a frame this cycle |
| in_smp | input | NUM_CH*SAMPLE_W | Samples; channel k in bits [k*SAMPLE_W +: SAMPLE_W] |
| in_v | input | NUM_CH | Validity bit per channel |
| in_u | input | NUM_CH | User bit per channel |
| in_c | input | NUM_CH | Channel-status bit per channel |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream accepts the word |
| m_tdata | output | 32 | Formatted channel word |
| m_tid | output | 3 | Channel number of the word |

## Verification
Two events can fall in the same cycle. The first is the hand-off of the last channel word of a frame. The second is the block-count rollover that decides the preamble of the next frame's channel 0. The bench drives small block lengths (3 and 4 frames) and an uneven `m_tready` pattern, so this rollover occurs many times under both stall and full throughput. It judges every word against a model that counts frames and channels on its own. A second collision is a frame offer on the same cycle the output is still busy. The bench drives changing garbage samples with `in_valid` high while `in_ready` is low, and the arithmetic model confirms that only the data accepted at the handshake ever appears on the output.

// File: rtl/psp_pkg.sv
package psp_pkg;
  localparam int FIELD_W = 24;
  localparam int TID_W   = 3;

  typedef enum logic [3:0] {
    PRE_BLOCK = 4'b0001,
    PRE_LEFT  = 4'b0010,
    PRE_RIGHT = 4'b0011
  } pre_e;

  typedef struct packed {
    logic               par;
    logic               cs;
    logic               usr;
    logic               vld;
    logic [FIELD_W-1:0] field;
    pre_e               pre;
  } aud_word_t;
endpackage

// File: rtl/psp_place.sv
module psp_place #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0]          smp,
  output logic [psp_pkg::FIELD_W-1:0]  field
);
  localparam int PAD_W = psp_pkg::FIELD_W - SAMPLE_W;

  generate
    if (PAD_W == 0) begin : g_full
      assign field = smp;
    end else begin : g_pad
      // left-justify the sample, zero below it
      assign field = {smp, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/psp_fmt.sv
module psp_fmt (
  input  logic [psp_pkg::FIELD_W-1:0] field,
  input  logic                        vld,
  input  logic                        usr,
  input  logic                        cs,
  input  logic [psp_pkg::TID_W-1:0]   ch,
  input  logic                        blk_first,
  output psp_pkg::aud_word_t          word
);
  import psp_pkg::*;

  always_comb begin
    word.field = field;
    word.vld   = vld;
    word.usr   = usr;
    word.cs    = cs;
    if (blk_first)  word.pre = PRE_BLOCK;
    else if (ch[0]) word.pre = PRE_RIGHT;
    else            word.pre = PRE_LEFT;
    word.par = ^{cs, usr, vld, field};
  end
endmodule

// File: rtl/psp_seq.sv
module psp_seq #(
  parameter int NUM_CH           = 8,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      advance,
  output logic [psp_pkg::TID_W-1:0] ch,
  output logic                      last,
  output logic                      first_frame
);
  localparam int FR_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [FR_W-1:0] FR_MAX = FR_W'(FRAMES_PER_BLOCK - 1);
  localparam logic [psp_pkg::TID_W-1:0] CH_MAX = psp_pkg::TID_W'(NUM_CH - 1);

  logic [FR_W-1:0] frame;

  assign last        = (ch == CH_MAX);
  assign first_frame = (frame == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch    <= '0;
      frame <= '0;
    end else if (start) begin
      ch <= '0;
    end else if (advance) begin
      if (last) begin
        ch    <= '0;
        frame <= (frame == FR_MAX) ? '0 : frame + 1'b1;
      end else begin
        ch <= ch + 1'b1;
      end
    end
  end

  // R10: the block count restarts after its final frame
  a_r10_block_wrap: assert property (@(posedge clk) disable iff (rst)
    advance && last && (frame == FR_MAX) |=> first_frame);

  // R4: channel index never reaches past the active channel count
  a_r4_ch_bound: assert property (@(posedge clk) disable iff (rst)
    ch <= CH_MAX);
endmodule

// File: rtl/pcm_stream_packer.sv
module pcm_stream_packer #(
  parameter int NUM_CH           = 8,
  parameter int SAMPLE_W         = 24,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0]   in_smp,
  input  logic [NUM_CH-1:0]            in_v,
  input  logic [NUM_CH-1:0]            in_u,
  input  logic [NUM_CH-1:0]            in_c,
  output logic                         m_tvalid,
  input  logic                         m_tready,
  output logic [31:0]                  m_tdata,
  output logic [2:0]                   m_tid
);
  import psp_pkg::*;

  localparam logic [TID_W-1:0] CH_MAX = TID_W'(NUM_CH - 1);

  logic                       load, xfer, last, first_frame;
  logic [TID_W-1:0]           cur_ch, src_ch;
  logic [NUM_CH*SAMPLE_W-1:0] hold_smp;
  logic [NUM_CH-1:0]          hold_v, hold_u, hold_c;
  logic [NUM_CH-1:0]          sh_v, sh_u, sh_c;
  logic [SAMPLE_W-1:0]        lane_smp;
  logic                       lane_v, lane_u, lane_c;
  logic [FIELD_W-1:0]         field;
  aud_word_t                  word;

  assign in_ready = !m_tvalid;
  assign load     = in_valid && in_ready;
  assign xfer     = m_tvalid && m_tready;
  assign src_ch   = load ? '0 : cur_ch + 1'b1;
  assign m_tid    = cur_ch;

  psp_seq #(
    .NUM_CH          (NUM_CH),
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (load),
    .advance    (xfer),
    .ch         (cur_ch),
    .last       (last),
    .first_frame(first_frame)
  );

  // frame capture: lanes 1.. are read from here after channel 0 leaves
  always_ff @(posedge clk) begin
    if (load) begin
      hold_smp <= in_smp;
      hold_v   <= in_v;
      hold_u   <= in_u;
      hold_c   <= in_c;
    end
  end

  assign sh_v = hold_v >> src_ch;
  assign sh_u = hold_u >> src_ch;
  assign sh_c = hold_c >> src_ch;

  always_comb begin
    if (load) begin
      lane_smp = in_smp[SAMPLE_W-1:0];
      lane_v   = in_v[0];
      lane_u   = in_u[0];
      lane_c   = in_c[0];
    end else begin
      lane_smp = hold_smp[int'(src_ch)*SAMPLE_W +: SAMPLE_W];
      lane_v   = sh_v[0];
      lane_u   = sh_u[0];
      lane_c   = sh_c[0];
    end
  end

  psp_place #(.SAMPLE_W(SAMPLE_W)) u_place (
    .smp  (lane_smp),
    .field(field)
  );

  psp_fmt u_fmt (
    .field    (field),
    .vld      (lane_v),
    .usr      (lane_u),
    .cs       (lane_c),
    .ch       (src_ch),
    .blk_first(load && first_frame),
    .word     (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
    end else if (load) begin
      m_tvalid <= 1'b1;
      m_tdata  <= word;
    end else if (xfer) begin
      if (last) m_tvalid <= 1'b0;
      else      m_tdata  <= word;
    end
  end

  // R8: a stalled word is held unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tid));

  // R4: a transferred non-final word is followed by the next channel
  a_r4_ascend: assert property (@(posedge clk) disable iff (rst)
    xfer && (m_tid != CH_MAX) |=> m_tvalid && (m_tid == 3'($past(m_tid) + 3'd1)));

  // R4: a new frame always opens on channel 0
  a_r4_frame_open: assert property (@(posedge clk) disable iff (rst)
    load |=> m_tvalid && (m_tid == '0));

  // R7: even parity over bits 31:4
  a_r7_parity: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (^m_tdata[31:4]) == 1'b0);

  // R3: odd channels are always marked right
  a_r3_odd_code: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tid[0] |-> m_tdata[3:0] == 4'b0011);

  // R11: reset drops the output valid
  a_r11_reset: assert property (@(posedge clk)
    rst |=> !m_tvalid);

  generate
    if (SAMPLE_W < FIELD_W) begin : g_pad_chk
      // R6: padding bits below a short sample stay zero
      a_r6_pad_zero: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> m_tdata[FIELD_W-SAMPLE_W+3:4] == '0);
    end
  endgenerate
endmodule

// File: tb/tb_pcm_stream_packer.sv
module tb_lane #(
  parameter int NUM_CH = 4,
  parameter int SAMPLE_W = 24,
  parameter int FRAMES = 4,
  parameter int NFR = 14,
  parameter int RST_AT = 9,
  parameter int LANE = 0
) (
  input  logic clk,
  output int   n_chk,
  output int   n_err,
  output logic done
);
  logic                       rst, in_valid, in_ready, m_tvalid, m_tready;
  logic [NUM_CH*SAMPLE_W-1:0] in_smp, exp_smp;
  logic [NUM_CH-1:0]          in_v, in_u, in_c, exp_v, exp_u, exp_c;
  logic [31:0]                m_tdata, prev_data, ew;
  logic [2:0]                 m_tid, prev_tid;

  pcm_stream_packer #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .FRAMES_PER_BLOCK(FRAMES)
  ) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_smp(in_smp), .in_v(in_v), .in_u(in_u), .in_c(in_c),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tid(m_tid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s lane%0d %s: actual=%h expected=%h", req, LANE, what, act, exp);
    end
  endtask

  function automatic logic [SAMPLE_W-1:0] gen_smp(input int n, input int k);
    if (n % 5 == 0) return '1;
    if (n % 5 == 1) return '0;
    return SAMPLE_W'(n * 40503 + k * 2654435 + 32'h1234567);
  endfunction

  function automatic logic [31:0] mk_word(input logic [SAMPLE_W-1:0] s, input logic v,
                                          input logic u, input logic c, input int ch, input int fr);
    logic [23:0] f;
    logic [3:0]  pre;
    f = 24'(s) << (24 - SAMPLE_W);
    if (ch == 0 && fr == 0) pre = 4'b0001;
    else if (ch % 2 == 1)   pre = 4'b0011;
    else                    pre = 4'b0010;
    return {^{c, u, v, f}, c, u, v, f, pre};
  endfunction

  initial begin
    int  n, exp_ch, exp_fr, sent, cyc;
    bit  prev_stall, did_rst;
    n_chk = 0; n_err = 0; done = 1'b0;
    n = 0; exp_ch = 0; exp_fr = 0; sent = 0; cyc = 0;
    prev_stall = 0; did_rst = 0;
    prev_data = '0; prev_tid = '0;
    rst = 1'b1; in_valid = 1'b0; m_tready = 1'b0;
    in_smp = '0; in_v = '0; in_u = '0; in_c = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!m_tvalid, "R11", "tvalid after reset", 32'(m_tvalid), 0);
    chk(in_ready, "R11", "in_ready after reset", 32'(in_ready), 1);
    while (sent < NFR) begin
      @(negedge clk);
      if (prev_stall)
        chk(m_tvalid && m_tdata == prev_data && m_tid == prev_tid, "R8", "stalled word",
            m_tdata, prev_data);
      if (!did_rst && sent == RST_AT && m_tvalid && exp_ch == 1) begin
        did_rst = 1;
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!m_tvalid, "R11", "tvalid after mid-frame reset", 32'(m_tvalid), 0);
        chk(in_ready, "R11", "in_ready after mid-frame reset", 32'(in_ready), 1);
        exp_ch = 0; exp_fr = 0; prev_stall = 0;
        continue;
      end
      // uneven backpressure; full throughput during the first frames
      m_tready = (sent < 2) ? 1'b1 : (((cyc * 5 + cyc / 11) % 4) != 0);
      in_valid = (cyc % 3) != 1;
      for (int k = 0; k < NUM_CH; k++) begin
        // R9: while busy, garbage is offered and must never appear
        in_smp[k*SAMPLE_W +: SAMPLE_W] = in_ready ? gen_smp(n, k) : ~gen_smp(n + 7, k);
        in_v[k] = in_ready ? ((n + k) % 3 == 0) : 1'bx;
        in_u[k] = in_ready ? (((n * k) & 1) == 1) : ~(((n * k) & 1) == 1);
        in_c[k] = in_ready ? ((((n >> 1) ^ k) & 1) == 1) : ~((((n >> 1) ^ k) & 1) == 1);
      end
      #1;
      chk(in_ready == !m_tvalid, "R9", "in_ready versus pending word", 32'(in_ready),
          32'(!m_tvalid));
      if (in_valid && in_ready) begin
        exp_smp = in_smp; exp_v = in_v; exp_u = in_u; exp_c = in_c;
        exp_ch = 0; n++;
      end
      if (m_tvalid && m_tready) begin
        ew = mk_word(exp_smp[exp_ch*SAMPLE_W +: SAMPLE_W], exp_v[exp_ch], exp_u[exp_ch],
                     exp_c[exp_ch], exp_ch, exp_fr);
        chk(m_tid == 3'(exp_ch), "R4", "channel id", 32'(m_tid), 32'(exp_ch));
        chk(m_tdata[30:28] == ew[30:28], "R1", "C/U/V bits", 32'(m_tdata[30:28]),
            32'(ew[30:28]));
        if (SAMPLE_W == 24)
          chk(m_tdata[27:4] == ew[27:4], "R5", "24-bit field", m_tdata, ew);
        else
          chk(m_tdata[27:4] == ew[27:4], "R6", "16-bit field and pad", m_tdata, ew);
        chk(m_tdata[31] == ew[31] && ^m_tdata[31:4] == 1'b0, "R7", "parity", m_tdata, ew);
        if (exp_ch == 0 && exp_fr == 0)
          chk(m_tdata[3:0] == 4'b0001, "R2", "block start code", 32'(m_tdata[3:0]), 1);
        else if (exp_ch == 0)
          chk(m_tdata[3:0] == 4'b0010, "R10", "frame start in block", 32'(m_tdata[3:0]), 2);
        else
          chk(m_tdata[3:0] == ew[3:0], "R3", "left/right code", 32'(m_tdata[3:0]),
              32'(ew[3:0]));
        if (exp_ch == NUM_CH - 1) begin
          exp_ch = 0; exp_fr = (exp_fr + 1) % FRAMES; sent++;
        end else begin
          exp_ch++;
        end
      end
      prev_stall = m_tvalid && !m_tready;
      prev_data  = m_tdata;
      prev_tid   = m_tid;
      cyc++;
    end
    in_valid = 1'b0;
    done = 1'b1;
  end
endmodule

module tb_pcm_stream_packer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int   c0, e0, c1, e1, c2, e2;
  logic d0, d1, d2;

  tb_lane #(.NUM_CH(4), .SAMPLE_W(24), .FRAMES(4),   .NFR(14),  .RST_AT(9),   .LANE(0))
    u_l0 (.clk(clk), .n_chk(c0), .n_err(e0), .done(d0));
  tb_lane #(.NUM_CH(2), .SAMPLE_W(16), .FRAMES(3),   .NFR(10),  .RST_AT(7),   .LANE(1))
    u_l1 (.clk(clk), .n_chk(c1), .n_err(e1), .done(d1));
  tb_lane #(.NUM_CH(8), .SAMPLE_W(24), .FRAMES(192), .NFR(200), .RST_AT(196), .LANE(2))
    u_l2 (.clk(clk), .n_chk(c2), .n_err(e2), .done(d2));

  initial begin
    int cyc;
    int wd_chk;
    int wd_err;
    cyc = 0; wd_chk = 0; wd_err = 0;
    @(posedge clk);
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1)) begin
      wd_chk = 1; wd_err = 1;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors",
             c0 + c1 + c2 + wd_chk, e0 + e1 + e2 + wd_err);
    $finish;
  end
endmodule